// File: doc/BRIEF.md
# Function-Unit Dependency Matrix Scoreboard

This block keeps a square array of single-bit dependency cells with one row and one column for each function unit, load and store units included. A set cell in row `i`, column `j` means unit `i` must wait for unit `j` to write its result. When an instruction is dispatched to a free unit, the block compares the new source and destination register numbers against the destinations of the units already in flight. It then fills that unit's row with true-data cells and ordering cells.

From the array contents the block drives two grants for each unit. The operand-read grant lets a unit start executing as soon as its true-data dependencies are gone, even when it may not yet write. The unit buffers its result until the write grant arrives and it signals completion. Each unit has a write-prevention input, held while an exception or a mispredicted path is still possible, and a kill input that discards the unit. The ordering cells come in two variants chosen by a parameter. In program-order mode each new unit depends on every unit in flight, so only the oldest can complete. In destination-only mode it depends only on in-flight units that write the same register.

Top module: `fu_dep_matrix`

## Requirements
- R1: After reset no unit is busy, and every read grant and every write grant is low.
- R2: A dispatch is accepted only when the addressed unit is free. The unit index is a binary number on `disp_unit`, and the unit is busy from the next cycle on. A dispatch to a busy unit is ignored and leaves that unit's dependency row unchanged.
- R3: A unit dispatched while a busy unit's destination register equals either of its source registers keeps its read grant low until that writer completes or is killed.
- R4: `grant_wr[i]` is high exactly when unit `i` is busy, its dependency row is empty and `wr_block[i]` is low. It responds to `wr_block` in the same cycle.
- R5: While `wr_block[i]` is high, a `wr_done[i]` pulse is ignored and the unit stays busy.
- R6: `wr_done[i]` with `grant_wr[i]` high frees unit `i` on the next clock edge and clears column `i` in every row.
- R7: `kill[i]` frees unit `i` on the next clock edge and clears both its row and its column, whatever its grants are. A dispatch to a unit in the same cycle as its kill is not accepted.
- R8: In program-order mode (`ORDER_MODE = ORD_PROGRAM`), a newly dispatched unit gets an ordering cell against every busy unit, so at most one busy unit has an empty ordering row and writes complete in dispatch order.
- R9: In destination-only mode (`ORDER_MODE = ORD_WAW`), ordering cells are set only against busy units whose destination register equals the new destination.
- R10: When a dispatch and a completion or kill of another unit fall in the same cycle, the clear wins and the new row gets no cell for that unit.
- R11: The read grant ignores the ordering cells and `wr_block`, so a unit may read operands while its write is still held back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_unit | input | UNIT_W | Binary index of the unit receiving the dispatch |
| disp_src_a | input | REG_W | First source register number |
| disp_src_b | input | REG_W | Second source register number |
| disp_dst | input | REG_W | Destination register number |
| wr_block | input | NUM_FU | Per-unit write-prevention hold |
| kill | input | NUM_FU | Per-unit discard |
| wr_done | input | NUM_FU | Per-unit result written (completion) |
| busy | output | NUM_FU | Unit holds an instruction |
| grant_rd | output | NUM_FU | Unit may read its operands |
| grant_wr | output | NUM_FU | Unit may write its result |

## Verification
The bench builds chains in which a consumer reads the register of a held producer. It then checks that the consumer's read stays closed while a younger independent unit may read but not write. A design that mixed up the two grants would either let the younger unit write ahead of older ones or stall its execution for no reason. Completion pulses are sent while write-prevention is high, and a design that honoured them would lose a result that might still fault. Kills are issued together with a dispatch to the killed unit, and completions together with a dispatch that depends on the completing unit. A design with the wrong priority would leave a stale cell that blocks the newcomer forever, or would revive a discarded unit. One stimulus stream drives both ordering variants, which must then differ only where the destinations differ.

// File: rtl/fudm_pkg.sv
package fudm_pkg;

   typedef enum logic {
      ORD_PROGRAM = 1'b0,
      ORD_WAW     = 1'b1
   } order_mode_e;

endpackage

// File: rtl/fudm_issue_decode.sv
module fudm_issue_decode #(
   parameter int unsigned          NUM_FU     = 4,
   parameter int unsigned          REG_W      = 3,
   parameter fudm_pkg::order_mode_e ORDER_MODE = fudm_pkg::ORD_PROGRAM
) (
   input  logic [NUM_FU-1:0]            busy,
   input  logic [NUM_FU-1:0][REG_W-1:0] dst_tab,
   input  logic [REG_W-1:0]             src_a,
   input  logic [REG_W-1:0]             src_b,
   input  logic [REG_W-1:0]             dst,
   output logic [NUM_FU-1:0]            raw_vec,
   output logic [NUM_FU-1:0]            ord_vec
);

   logic [NUM_FU-1:0] same_dst;

   for (genvar j = 0; j < NUM_FU; j++) begin : g_cmp
      assign raw_vec[j]  = busy[j] & ((dst_tab[j] == src_a) | (dst_tab[j] == src_b));
      assign same_dst[j] = busy[j] & (dst_tab[j] == dst);
   end

   if (ORDER_MODE == fudm_pkg::ORD_PROGRAM) begin : g_prog
      assign ord_vec = busy;
   end else begin : g_waw
      assign ord_vec = same_dst;
   end

endmodule

// File: rtl/fudm_row.sv
module fudm_row #(
   parameter int unsigned NUM_FU  = 4,
   parameter int unsigned ROW_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NUM_FU-1:0] raw_in,
   input  logic [NUM_FU-1:0] ord_in,
   input  logic [NUM_FU-1:0] col_clr,
   input  logic              row_clr,
   output logic [NUM_FU-1:0] raw_q,
   output logic [NUM_FU-1:0] ord_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         ord_q <= '0;
      end else if (row_clr) begin
         raw_q <= '0;
         ord_q <= '0;
      end else if (load) begin
         raw_q <= raw_in & ~col_clr;
         ord_q <= ord_in & ~col_clr;
      end else begin
         raw_q <= raw_q & ~col_clr;
         ord_q <= ord_q & ~col_clr;
      end
   end

   AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_q[ROW_IDX] && !ord_q[ROW_IDX]); // R3

endmodule

// File: rtl/fudm_grant.sv
module fudm_grant #(
   parameter int unsigned NUM_FU = 4
) (
   input  logic [NUM_FU-1:0][NUM_FU-1:0] raw_rows,
   input  logic [NUM_FU-1:0][NUM_FU-1:0] ord_rows,
   input  logic [NUM_FU-1:0]             busy,
   input  logic [NUM_FU-1:0]             hold,
   output logic [NUM_FU-1:0]             go_rd,
   output logic [NUM_FU-1:0]             go_wr
);

   for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
      logic data_clear;
      logic order_clear;
      assign data_clear  = ~|raw_rows[i];
      assign order_clear = ~|ord_rows[i];
      assign go_rd[i]    = busy[i] & data_clear;
      assign go_wr[i]    = busy[i] & data_clear & order_clear & ~hold[i];
   end

endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
   parameter int unsigned           NUM_FU     = 4,
   parameter int unsigned           NUM_REG    = 8,
   parameter fudm_pkg::order_mode_e ORDER_MODE = fudm_pkg::ORD_PROGRAM,
   localparam int unsigned          UNIT_W     = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int unsigned          REG_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [UNIT_W-1:0] disp_unit,
   input  logic [REG_W-1:0]  disp_src_a,
   input  logic [REG_W-1:0]  disp_src_b,
   input  logic [REG_W-1:0]  disp_dst,
   input  logic [NUM_FU-1:0] wr_block,
   input  logic [NUM_FU-1:0] kill,
   input  logic [NUM_FU-1:0] wr_done,
   output logic [NUM_FU-1:0] busy,
   output logic [NUM_FU-1:0] grant_rd,
   output logic [NUM_FU-1:0] grant_wr
);

   if (NUM_FU < 2) begin : g_bad_fu
      $error("fu_dep_matrix: NUM_FU must be at least 2");
   end
   if (NUM_REG < 2) begin : g_bad_reg
      $error("fu_dep_matrix: NUM_REG must be at least 2");
   end

   logic [NUM_FU-1:0]              busy_q;
   logic [NUM_FU-1:0][REG_W-1:0]   dst_q;
   logic [NUM_FU-1:0][NUM_FU-1:0]  raw_rows;
   logic [NUM_FU-1:0][NUM_FU-1:0]  ord_rows;
   logic [NUM_FU-1:0]              raw_new;
   logic [NUM_FU-1:0]              ord_new;
   logic [NUM_FU-1:0]              load_vec;
   logic [NUM_FU-1:0]              commit_eff;
   logic [NUM_FU-1:0]              clr_vec;
   logic [NUM_FU-1:0]              go_rd_w;
   logic [NUM_FU-1:0]              go_wr_w;

   assign commit_eff = wr_done & go_wr_w;
   assign clr_vec    = kill | commit_eff;

   fudm_issue_decode #(
      .NUM_FU     (NUM_FU),
      .REG_W      (REG_W),
      .ORDER_MODE (ORDER_MODE)
   ) u_decode (
      .busy    (busy_q),
      .dst_tab (dst_q),
      .src_a   (disp_src_a),
      .src_b   (disp_src_b),
      .dst     (disp_dst),
      .raw_vec (raw_new),
      .ord_vec (ord_new)
   );

   for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
      assign load_vec[i] = disp_valid && (disp_unit == UNIT_W'(i)) &&
                           !busy_q[i] && !kill[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q[i] <= 1'b0;
            dst_q[i]  <= '0;
         end else if (clr_vec[i]) begin
            busy_q[i] <= 1'b0;
         end else if (load_vec[i]) begin
            busy_q[i] <= 1'b1;
            dst_q[i]  <= disp_dst;
         end
      end

      fudm_row #(
         .NUM_FU  (NUM_FU),
         .ROW_IDX (i)
      ) u_row (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load_vec[i]),
         .raw_in  (raw_new),
         .ord_in  (ord_new),
         .col_clr (clr_vec),
         .row_clr (clr_vec[i]),
         .raw_q   (raw_rows[i]),
         .ord_q   (ord_rows[i])
      );

      logic [NUM_FU-1:0] col_bits;
      for (genvar k = 0; k < NUM_FU; k++) begin : g_col
         assign col_bits[k] = raw_rows[k][i] | ord_rows[k][i];
      end

      AST_HOLD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         busy_q[i] && wr_block[i] && !kill[i] |=> busy_q[i]); // R5
      AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
         kill[i] |=> !busy_q[i]); // R7
      AST_IDLE_ROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_q[i] |-> (raw_rows[i] == '0) && (ord_rows[i] == '0)); // R6
      AST_COLUMN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vec[i] |=> (col_bits == '0)); // R10
   end

   fudm_grant #(
      .NUM_FU (NUM_FU)
   ) u_grant (
      .raw_rows (raw_rows),
      .ord_rows (ord_rows),
      .busy     (busy_q),
      .hold     (wr_block),
      .go_rd    (go_rd_w),
      .go_wr    (go_wr_w)
   );

   if (ORDER_MODE == fudm_pkg::ORD_PROGRAM) begin : g_prog_chk
      logic [NUM_FU-1:0] order_free;
      for (genvar i = 0; i < NUM_FU; i++) begin : g_of
         assign order_free[i] = busy_q[i] & ~|ord_rows[i];
      end
      AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(order_free) <= 1); // R8
   end

   assign busy     = busy_q;
   assign grant_rd = go_rd_w;
   assign grant_wr = go_wr_w;

endmodule

// File: tb/fu_dep_matrix_test.sv
module fu_dep_matrix_test;

   localparam int NFU = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       disp_valid = 1'b0;
   logic [1:0] disp_unit = '0;
   logic [2:0] disp_src_a = '0;
   logic [2:0] disp_src_b = '0;
   logic [2:0] disp_dst = '0;
   logic [3:0] wr_block = '0;
   logic [3:0] kill = '0;
   logic [3:0] wr_done = '0;
   logic [3:0] busy, grant_rd, grant_wr;
   logic [3:0] busy_w, grant_rd_w, grant_wr_w;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   fu_dep_matrix #(.NUM_FU(NFU), .NUM_REG(8), .ORDER_MODE(fudm_pkg::ORD_PROGRAM)) uut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_unit(disp_unit),
      .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
      .wr_block(wr_block), .kill(kill), .wr_done(wr_done),
      .busy(busy), .grant_rd(grant_rd), .grant_wr(grant_wr));

   fu_dep_matrix #(.NUM_FU(NFU), .NUM_REG(8), .ORDER_MODE(fudm_pkg::ORD_WAW)) uut_waw (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_unit(disp_unit),
      .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
      .wr_block(wr_block), .kill(kill), .wr_done(wr_done),
      .busy(busy_w), .grant_rd(grant_rd_w), .grant_wr(grant_wr_w));

   task automatic check(input string req, input string what,
                        input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic dispatch(input logic [1:0] u, input logic [2:0] sa,
                           input logic [2:0] sb, input logic [2:0] d);
      disp_valid = 1'b1; disp_unit = u;
      disp_src_a = sa; disp_src_b = sb; disp_dst = d;
      tick();
      disp_valid = 1'b0;
   endtask

   task automatic test_reset();
      check("R1", "busy",     busy,     4'b0000);
      check("R1", "grant_rd", grant_rd, 4'b0000);
      check("R1", "grant_wr", grant_wr, 4'b0000);
      check("R1", "waw busy", busy_w,   4'b0000);
   endtask

   task automatic test_chain_and_order();
      wr_block = 4'b0001;
      dispatch(2'd0, 3'd2, 3'd3, 3'd1);
      check("R2", "busy after dispatch", busy, 4'b0001);
      check("R11", "u0 reads while held", grant_rd, 4'b0001);
      check("R4", "no write while held", grant_wr, 4'b0000);
      dispatch(2'd1, 3'd1, 3'd2, 3'd4);
      check("R3", "consumer read blocked", grant_rd, 4'b0001);
      dispatch(2'd2, 3'd6, 3'd7, 3'd5);
      check("R11", "independent unit reads", grant_rd, 4'b0101);
      check("R8", "younger unit write blocked", grant_wr, 4'b0000);
      check("R9", "waw mode lets u2 write", grant_wr_w, 4'b0100);
      dispatch(2'd1, 3'd6, 3'd7, 3'd0);
      check("R2", "redispatch to busy ignored", grant_rd, 4'b0101);
      wr_done = 4'b0001;
      tick();
      wr_done = 4'b0000;
      check("R5", "completion under hold ignored", busy, 4'b0111);
      wr_block = 4'b0000;
      #1;
      check("R4", "hold release opens write", grant_wr, 4'b0001);
      wr_done = 4'b0001;
      tick();
      wr_done = 4'b0000;
      check("R6", "u0 freed", busy, 4'b0110);
      check("R6", "column cleared reads", grant_rd, 4'b0110);
      check("R8", "only next oldest writes", grant_wr, 4'b0010);
      wr_done = 4'b0010;
      tick();
      wr_done = 4'b0000;
      check("R8", "last unit writes after older", grant_wr, 4'b0100);
      wr_done = 4'b0100;
      tick();
      wr_done = 4'b0000;
      check("R6", "all complete", busy, 4'b0000);
      check("R6", "waw all complete", busy_w, 4'b0000);
   endtask

   task automatic test_kill();
      wr_block = 4'b0001;
      dispatch(2'd0, 3'd0, 3'd0, 3'd3);
      dispatch(2'd1, 3'd3, 3'd3, 3'd3);
      check("R3", "dependent read blocked", grant_rd, 4'b0001);
      kill = 4'b0101;
      disp_valid = 1'b1; disp_unit = 2'd2;
      disp_src_a = 3'd6; disp_src_b = 3'd6; disp_dst = 3'd6;
      tick();
      disp_valid = 1'b0; kill = 4'b0000;
      check("R7", "kill frees and blocks dispatch", busy, 4'b0010);
      check("R7", "killed column cleared rd", grant_rd, 4'b0010);
      check("R7", "killed column cleared wr", grant_wr, 4'b0010);
      kill = 4'b0010;
      tick();
      kill = 4'b0000;
      wr_block = 4'b0000;
      check("R7", "kill of granted unit", busy, 4'b0000);
   endtask

   task automatic test_same_cycle();
      dispatch(2'd0, 3'd0, 3'd1, 3'd2);
      check("R4", "free unit writes", grant_wr, 4'b0001);
      wr_done = 4'b0001;
      disp_valid = 1'b1; disp_unit = 2'd1;
      disp_src_a = 3'd2; disp_src_b = 3'd2; disp_dst = 3'd5;
      tick();
      disp_valid = 1'b0; wr_done = 4'b0000;
      check("R10", "busy after overlap", busy, 4'b0010);
      check("R10", "no stale read cell", grant_rd, 4'b0010);
      check("R10", "no stale write cell", grant_wr, 4'b0010);
      check("R10", "waw no stale cell", grant_wr_w, 4'b0010);
      wr_done = 4'b0010;
      tick();
      wr_done = 4'b0000;
      check("R6", "cleanup", busy, 4'b0000);
   endtask

   task automatic test_waw_mode();
      wr_block = 4'b0001;
      dispatch(2'd0, 3'd0, 3'd0, 3'd6);
      dispatch(2'd1, 3'd1, 3'd1, 3'd6);
      dispatch(2'd2, 3'd2, 3'd2, 3'd7);
      check("R9", "waw read grants", grant_rd_w, 4'b0111);
      check("R9", "waw write grants", grant_wr_w, 4'b0100);
      check("R8", "program order write grants", grant_wr, 4'b0000);
      kill = 4'b0111;
      tick();
      kill = 4'b0000;
      wr_block = 4'b0000;
      check("R7", "flush all", busy, 4'b0000);
      check("R7", "waw flush all", busy_w, 4'b0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      test_reset();
      rst_n = 1'b1;
      tick();
      test_reset();
      test_chain_and_order();
      test_kill();
      test_same_cycle();
      test_waw_mode();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule